// File: doc/BRIEF.md
# FIFO Threshold Offset Loader and Almost Flags

This block holds the two thresholds that decide when a FIFO reports that it is almost empty or almost full. Each threshold is 16 bits wide and is held as two bytes. Software sets the thresholds through the FIFO's own 8-bit data path. While the load strobe is held low, each write-enabled clock stores one byte. A read-enabled clock instead returns one byte. A single two-bit selector picks the byte to access. It steps through the four bytes in a fixed cycle, and it keeps its position between separate load sessions.

The block also forms the two almost flags, both active low. It compares the FIFO fill level with the empty threshold, and the free space with the full threshold. Only the bits that fit the FIFO's address width take part. The storage array and its pointers live outside the block and supply the fill level. The load and readback sides share one clock, `clk`.

Top module: `fifo_thresh_seq`

## Requirements
- R1: After reset, the selector points at byte 0. The threshold bytes are 7, 0, 7, 0 for bytes 0 to 3. `rb_data` is 0 and `rb_valid` is 0. `almost_empty_n` is 0 and `almost_full_n` is 1.
- R2: When `load_n` and `wr_en_n` are both low at a rising edge, `wr_byte` is stored in the selected byte. Bytes are taken in the order 0 (empty low), 1 (empty high), 2 (full low), 3 (full high).
- R3: An access made while byte 3 is selected moves the selector back to byte 0.
- R4: While `load_n` is high, the selector and the stored bytes do not change, whatever the other enables do. The next load session carries on from the byte after the last one accessed.
- R5: When `load_n`, `rd_en_a_n` and `rd_en_b_n` are all low and no load takes place, the selected byte appears on `rb_data` one cycle later, with `rb_valid` high. The selector then advances by one.
- R6: When a load and a readback are requested in the same cycle, the load wins. `rb_valid` stays low and `rb_data` keeps its value.
- R7: A cycle with `load_n` low but `wr_en_n` high leaves every stored byte unchanged.
- R8: One cycle after each edge, `almost_empty_n` is low exactly when `fill_level` is at or below the empty threshold, {byte1, byte0}.
- R9: One cycle after each edge, `almost_full_n` is low exactly when 2^ADDR_W minus `fill_level` is at or below the full threshold, {byte3, byte2}.
- R10: Threshold bits at or above bit ADDR_W are ignored. The thresholds are used modulo 2^ADDR_W.
- R11: `rb_data` holds its value in every cycle without a readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loads, readback and flags |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Threshold access strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| wr_byte | input | 8 | Byte to store during a load |
| fill_level | input | ADDR_W+1 | Current number of words in the FIFO (0 to 2^ADDR_W) |
| rb_data | output | 8 | Byte returned by a readback |
| rb_valid | output | 1 | High for one cycle after each readback |
| almost_empty_n | output | 1 | Almost-empty flag, active low, registered |
| almost_full_n | output | 1 | Almost-full flag, active low, registered |

## Verification
The assertions check on every cycle that:
- the selector holds while idle and wraps from byte 3 to byte 0;
- the stored bytes change only on a load;
- `rb_data` holds outside a readback, and a load suppresses `rb_valid`;
- both flags behave correctly at the extreme fill levels 0 and 2^ADDR_W.

Only the bench scenarios can show the rest:
- the byte order of a load sequence;
- a partial session that resumes at the right byte;
- the exact flag edges at a threshold and one word either side of it;
- the masking of threshold bits above the address width.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_OFS  = 4;
    localparam int unsigned SEL_W    = $clog2(NUM_OFS);
    localparam int unsigned THRESH_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] LO_RESET = 8'd7;
    localparam logic [BYTE_W-1:0] HI_RESET = 8'd0;

    // Selector order is behaviour: loads and readbacks walk it in this order.
    typedef enum logic [SEL_W-1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } ofs_sel_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_READ = 2'd2
    } ofs_op_e;

    typedef struct packed {
        logic [THRESH_W-1:0] empty_ofs;
        logic [THRESH_W-1:0] full_ofs;
    } thresh_t;

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return ofs_sel_e'(s + 2'd1);
    endfunction

    // Low bytes of each threshold reset to 7, high bytes to 0.
    function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned idx);
        return (idx % 2 == 0) ? LO_RESET : HI_RESET;
    endfunction

    function automatic logic [THRESH_W-1:0] join_bytes(
        input logic [BYTE_W-1:0] hi,
        input logic [BYTE_W-1:0] lo
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/fts_ctrl.sv
`timescale 1ns/1ps
module fts_ctrl
    import fts_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_n,
    input  logic     wr_en_n,
    input  logic     rd_en_a_n,
    input  logic     rd_en_b_n,
    output ofs_op_e  op,
    output ofs_sel_e sel
);

    logic load_req;
    logic read_req;

    assign load_req = !load_n && !wr_en_n;
    assign read_req = !load_n && !rd_en_a_n && !rd_en_b_n;

    // Load has priority; readback is dropped when both are requested.
    always_comb begin
        if (load_req)      op = OP_LOAD;
        else if (read_req) op = OP_READ;
        else               op = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst)                sel <= SEL_AE_LO;
        else if (op != OP_IDLE) sel <= next_sel(sel);
    end

    // R3: the selector wraps from the last byte to the first
    a_r3_sel_wrap: assert property (@(posedge clk) disable iff (rst)
        (op != OP_IDLE && sel == SEL_AF_HI) |=> (sel == SEL_AE_LO));

    // R4: the selector is kept while no access happens
    a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n) |=> $stable(sel));

endmodule

// File: rtl/fts_bank.sv
`timescale 1ns/1ps
module fts_bank
    import fts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ofs_op_e           op,
    input  ofs_sel_e          sel,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rb_data,
    output logic              rb_valid,
    output thresh_t           thresh
);

    logic [NUM_OFS-1:0][BYTE_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_OFS; i++) begin
            if (rst)
                ofs_q[i] <= reset_byte(i);
            else if (op == OP_LOAD && sel == ofs_sel_e'(SEL_W'(i)))
                ofs_q[i] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_data  <= '0;
            rb_valid <= 1'b0;
        end else begin
            rb_valid <= (op == OP_READ);
            if (op == OP_READ)
                rb_data <= ofs_q[sel];
        end
    end

    assign thresh.empty_ofs = join_bytes(ofs_q[SEL_AE_HI], ofs_q[SEL_AE_LO]);
    assign thresh.full_ofs  = join_bytes(ofs_q[SEL_AF_HI], ofs_q[SEL_AF_LO]);

    // R7: stored bytes only change on a load
    a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LOAD) |=> $stable(ofs_q));

    // R6: a load cycle never produces a readback
    a_r6_load_blocks_read: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> !rb_valid);

    // R11: readback data holds outside readback cycles
    a_r11_rb_hold: assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> $stable(rb_data));

endmodule

// File: rtl/fts_flags.sv
`timescale 1ns/1ps
module fts_flags
    import fts_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   fill_level,
    input  thresh_t           thresh,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    localparam int unsigned      CNT_W   = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << ADDR_W;

    logic [ADDR_W-1:0] e_off;
    logic [ADDR_W-1:0] f_off;
    logic [CNT_W-1:0]  free_cnt;
    logic              ae_hit;
    logic              af_hit;

    // Only address-width bits of each threshold are significant.
    assign e_off    = thresh.empty_ofs[ADDR_W-1:0];
    assign f_off    = thresh.full_ofs[ADDR_W-1:0];
    assign free_cnt = DEPTH_C - fill_level;
    assign ae_hit   = fill_level <= {1'b0, e_off};
    assign af_hit   = free_cnt   <= {1'b0, f_off};

    always_ff @(posedge clk) begin
        if (rst) begin
            almost_empty_n <= 1'b0;
            almost_full_n  <= 1'b1;
        end else begin
            almost_empty_n <= !ae_hit;
            almost_full_n  <= !af_hit;
        end
    end

    // R8: an empty FIFO is always almost empty
    a_r8_empty_at_zero: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |=> !almost_empty_n);

    // R8: a full FIFO is never almost empty (threshold below depth)
    a_r8_not_empty_at_depth: assert property (@(posedge clk) disable iff (rst)
        (fill_level == DEPTH_C) |=> almost_empty_n);

    // R9: a full FIFO is always almost full
    a_r9_full_at_depth: assert property (@(posedge clk) disable iff (rst)
        (fill_level == DEPTH_C) |=> !almost_full_n);

    // R9: an empty FIFO is never almost full
    a_r9_not_full_at_zero: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |=> almost_full_n);

endmodule

// File: rtl/fifo_thresh_seq.sv
`timescale 1ns/1ps
module fifo_thresh_seq
    import fts_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W:0]   fill_level,
    output logic [7:0]        rb_data,
    output logic              rb_valid,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    ofs_op_e  op;
    ofs_sel_e sel;
    thresh_t  thresh;

    fts_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .rd_en_a_n (rd_en_a_n),
        .rd_en_b_n (rd_en_b_n),
        .op        (op),
        .sel       (sel)
    );

    fts_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .sel      (sel),
        .wr_byte  (wr_byte),
        .rb_data  (rb_data),
        .rb_valid (rb_valid),
        .thresh   (thresh)
    );

    fts_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk            (clk),
        .rst            (rst),
        .fill_level     (fill_level),
        .thresh         (thresh),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    // R5: a readback cycle is always followed by a valid strobe
    a_r5_read_valid: assert property (@(posedge clk) disable iff (rst)
        (!load_n && wr_en_n && !rd_en_a_n && !rd_en_b_n) |=> rb_valid);

endmodule

// File: tb/fifo_thresh_seq_tb.sv
`timescale 1ns/1ps
module fifo_thresh_seq_tb;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CNT_W  = ADDR_W + 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             load_n, wr_en_n, rd_en_a_n, rd_en_b_n;
    logic [7:0]       wr_byte;
    logic [CNT_W-1:0] fill_level;
    logic [7:0]       rb_data;
    logic             rb_valid;
    logic             almost_empty_n, almost_full_n;

    always #2.5 clk = ~clk;

    fifo_thresh_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .wr_byte(wr_byte),
        .fill_level(fill_level), .rb_data(rb_data), .rb_valid(rb_valid),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    int checks = 0;
    int errors = 0;
    int m_reg [4];
    int m_ptr;
    logic [7:0] m_rb;
    logic m_rbv;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int thr(input int hi, input int lo);
        return ((hi << 8) | lo) % DEPTH;
    endfunction

    // One cycle: drive at a negedge, check at the next negedge.
    task automatic step(input logic ld, input logic we, input logic ra,
                        input logic rb, input int d, input int f,
                        input string tag);
        int  eoff, foff;
        bit  is_load, is_read;
        logic exp_ae, exp_af;
        load_n = ld; wr_en_n = we; rd_en_a_n = ra; rd_en_b_n = rb;
        wr_byte = 8'(d); fill_level = CNT_W'(f);
        eoff = thr(m_reg[1], m_reg[0]);
        foff = thr(m_reg[3], m_reg[2]);
        exp_ae = !(f <= eoff);
        exp_af = !((DEPTH - f) <= foff);
        is_load = !ld && !we;
        is_read = !ld && !ra && !rb && !is_load;
        if (is_load) begin
            m_reg[m_ptr] = d & 8'hFF;
            m_ptr = (m_ptr + 1) % 4;
        end else if (is_read) begin
            m_rb  = 8'(m_reg[m_ptr]);
            m_ptr = (m_ptr + 1) % 4;
        end
        m_rbv = is_read;
        @(negedge clk);
        chk(tag, int'(rb_valid), int'(m_rbv));
        chk(tag, int'(rb_data), int'(m_rb));
        chk("R8", int'(almost_empty_n), int'(exp_ae));
        chk("R9", int'(almost_full_n), int'(exp_af));
    endtask

    task automatic do_load(input int d, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b1, d, 100, tag);
    endtask

    task automatic do_read(input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, 0, 100, tag);
    endtask

    task automatic idle(input int f, input string tag);
        step(1'b1, 1'b1, 1'b1, 1'b1, 0, f, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        rst = 1'b1;
        load_n = 1'b1; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        wr_byte = '0; fill_level = '0;
        repeat (3) @(negedge clk);
        // R1: reset state at the outputs
        chk("R1", int'(rb_data), 0);
        chk("R1", int'(rb_valid), 0);
        chk("R1", int'(almost_empty_n), 0);
        chk("R1", int'(almost_full_n), 1);
        rst = 1'b0;
        m_reg = '{7, 0, 7, 0};
        m_ptr = 0; m_rb = '0; m_rbv = 1'b0;

        // R1: default bytes read back in order from byte 0
        for (int i = 0; i < 4; i++) do_read("R1");

        // R2: a full load sequence then readback
        do_load(8'h11, "R2"); do_load(8'h01, "R2");
        do_load(8'h22, "R2"); do_load(8'h00, "R2");
        for (int i = 0; i < 4; i++) do_read("R2");

        // R3: fifth load wraps to byte 0
        for (int i = 0; i < 5; i++) do_load(8'h30 + i, "R3");
        for (int i = 0; i < 4; i++) do_read("R3");

        // R4: partial session, strobe high ignores enables, then resume
        do_load(8'h05, "R4"); do_load(8'h06, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hEE, 100, "R4");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'hDD, 100, "R4");
        do_load(8'h09, "R4");
        for (int i = 0; i < 4; i++) do_read("R4");

        // R7: strobe low without write enable stores nothing
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAB, 100, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'hAB, 100, "R7");
        for (int i = 0; i < 4; i++) do_read("R7");

        // R6: load wins over a simultaneous readback
        do_read("R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h44, 100, "R6");
        // R11: data holds during idle cycles
        idle(100, "R11"); idle(100, "R11");

        // R10: high threshold bits beyond the address width are dropped
        while (m_ptr != 0) do_read("R10");
        do_load(8'h00, "R10"); do_load(8'hFC, "R10");
        idle(1, "R10");
        idle(1, "R10");
        chk("R10", int'(almost_empty_n), 1);
        idle(0, "R10");
        idle(0, "R10");
        chk("R10", int'(almost_empty_n), 0);

        // R8 / R9: flag edges around thresholds 20 (empty) and 30 (full)
        while (m_ptr != 0) do_read("R8");
        do_load(20, "R8"); do_load(0, "R8"); do_load(30, "R9"); do_load(0, "R9");
        idle(0, "R8");
        foreach (m_reg[k]) begin end
        idle(19, "R8"); idle(20, "R8"); idle(21, "R8"); idle(21, "R8");
        chk("R8", int'(almost_empty_n), 1);
        idle(20, "R8"); idle(20, "R8");
        chk("R8", int'(almost_empty_n), 0);
        idle(DEPTH - 29, "R9"); idle(DEPTH - 30, "R9");
        idle(DEPTH - 31, "R9"); idle(DEPTH - 31, "R9");
        chk("R9", int'(almost_full_n), 1);
        idle(DEPTH - 30, "R9"); idle(DEPTH - 30, "R9");
        chk("R9", int'(almost_full_n), 0);
        idle(DEPTH, "R9"); idle(0, "R9");

        // R5: random mix of loads, readbacks and fill levels
        for (int n = 0; n < 3000; n++) begin
            logic ld, we, ra, rb;
            int f;
            ld = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
            we = ($urandom_range(0, 2) == 0) ? 1'b0 : 1'b1;
            ra = ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0;
            rb = ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0;
            if ($urandom_range(0, 1) == 0)
                f = $urandom_range(0, DEPTH);
            else
                f = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 40)
                                                : DEPTH - $urandom_range(0, 40);
            step(ld, we, ra, rb, $urandom_range(0, 255), f, "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule